// File: doc/BRIEF.md
# Verified Serial DAC Update Sequencer

This block loads 32 bias settings into four serial DACs of eight channels each. The DACs share one serial clock. Each has its own chip select, data input and data output. The settings live in an external memory of 16-bit words. Each word carries a 10-bit value guarded by a 5-bit single-error-correcting, double-error-detecting code. Before a value is shifted out, the block checks its code. A single-bit fault is repaired and the repaired word is written back to memory. A word with a double fault is left out of the sequence.

Every word shifted into a DAC pushes the previous word back out on that DAC's data output. The block compares that returned word with what it sent. This gives a verdict for each channel. After a DAC's channel words, the block sends three control words. The first is a no-operation word that returns the last channel word for checking. The second tells the DAC to update its outputs, but only for channels that arrived intact. The third tells the DAC to drive every other channel to 0 V. The per-channel verdicts and double-fault flags are presented as two 32-bit status vectors.

A pass starts on a one-cycle update request. When the continuous input is high, passes follow one another with no request.

Top module: `dac_update_seq`

## Requirements
- R1: After reset, `busy` is 0, every `dac_cs_n` bit is 1, `dac_sclk` is 1, and `set_status` and `dbl_err` are all zero.
- R2: While idle, the block starts a pass when `update_req` is 1. With `update_req` and `continuous` both low, it stays idle and shifts nothing.
- R3: While `continuous` is 1, a new pass starts as soon as one ends, and `busy` stays 1. When `continuous` is low at the end of a pass, the block goes idle.
- R4: A word is 16 bits, sent MSB first. Chip select stays low for the whole word, and at most one chip select is low at any time. `dac_sclk` idles high and falls before each bit. `dac_din` is valid at the rising edge. The returned bit is taken at the same rising edge, after the DAC has changed it on the falling edge. Chip select goes high again between words.
- R5: DACs are served in order 0 to 3. For each DAC the sequence is: channel words for channels 0 to 7, then the NOOP word 0x8000, then the update word, then the power word. A channel word is {0, channel[2:0], value[9:0], 00}. Memory address = DAC*8 + channel.
- R6: A stored word is {code[4:0] in bits 15:11, unused bit 10, value in bits 9:0}. Data bit i sits at check position 3,5,6,7,9,10,11,12,13,14 (for i = 0..9). Code bit j (j < 4) is the XOR of the data bits whose position has bit j set. Bit 15 makes bits 15:11 and 9:0 together even parity. On a single-bit fault, the corrected word is written back (`mem_we` high, `mem_wdata` = corrected word) and the corrected value is sent.
- R7: On a double-bit fault, the channel's word is not sent, its `dbl_err` bit becomes 1 and its `set_status` bit becomes 0. A channel without a double fault gets `dbl_err` 0.
- R8: A sent channel's `set_status` bit becomes 1 if the word returned while the next word of the same DAC is shifted equals the sent word, and 0 otherwise.
- R9: The update word is 0xA000 with bits 7:0 set to that DAC's `set_status` bits. The power word is 0xC000 with bits 7:0 set to the complement of those bits.
- R10: The word returned during the first word of each DAC's sequence is not used. Data left in a DAC from power-up or from a previous pass does not affect any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| update_req | input | 1 | Start one pass when idle |
| continuous | input | 1 | Repeat passes while high |
| mem_addr | output | 5 | Setting memory read/write address |
| mem_rdata | input | 16 | Stored word at `mem_addr`, same cycle |
| mem_we | output | 1 | Write back a corrected word |
| mem_wdata | output | 16 | Corrected word |
| dac_sclk | output | 1 | Shared serial clock |
| dac_cs_n | output | 4 | Per-DAC chip select, active low |
| dac_din | output | 4 | Per-DAC serial data to DAC |
| dac_dout | input | 4 | Per-DAC serial data returned from DAC |
| busy | output | 1 | A pass is in progress |
| set_status | output | 32 | Per-channel: 1 = set and confirmed |
| dbl_err | output | 32 | Per-channel double-fault flag |

## Verification
The assertions assume the memory answers combinationally and holds `mem_rdata` steady for the address in the same cycle. They also assume `dac_dout` changes only near a falling serial clock edge. The bench memory model answers combinationally and writes at the clock edge. The bench DAC models update their data output one half system cycle after the block lowers the serial clock. Stimulus is applied only while the block is idle, or, for the continuous case, as level changes on `continuous`. Fault injection flips only bits 15:11 and 9:0, never bit 10, so the single-versus-double outcome is always defined.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    localparam logic [15:0] WORD_NOOP   = 16'h8000;
    localparam logic [15:0] WORD_UPDATE = 16'hA000;
    localparam logic [15:0] WORD_POWER  = 16'hC000;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_LOW,
        SH_HIGH,
        SH_GAP
    } sh_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_SEND,
        SQ_WAIT
    } sq_state_e;

    // check position of data bit i: the i-th non power of two from 3 upward
    function automatic logic [3:0] data_pos(input int i);
        logic [3:0] r;
        int         n;
        r = '0;
        n = 0;
        for (int p = 3; p < 16; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == i) r = p[3:0];
                n++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dac_hamming_dec.sv
module dac_hamming_dec
    import dac_seq_pkg::*;
(
    input  logic [15:0] word_i,
    output logic [15:0] fixed_o,
    output logic        single_o,
    output logic        double_o
);

    logic [9:0] data;
    logic [3:0] syn;
    logic       par;

    always_comb begin
        data = word_i[9:0];
        syn  = word_i[14:11];
        for (int i = 0; i < 10; i++) begin
            syn = syn ^ (data_pos(i) & {4{data[i]}});
        end
        par      = (^word_i[15:11]) ^ (^data);
        single_o = par;
        double_o = !par && (syn != 4'd0);
        fixed_o  = word_i;
        if (par) begin
            if (syn == 4'd0) begin
                fixed_o[15] = !word_i[15];
            end else begin
                for (int j = 0; j < 4; j++) begin
                    if (syn == 4'(1 << j)) fixed_o[11+j] = !word_i[11+j];
                end
                for (int i = 0; i < 10; i++) begin
                    if (syn == data_pos(i)) fixed_o[i] = !word_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/dac_word_shifter.sv
module dac_word_shifter
    import dac_seq_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [15:0] word_i,
    input  logic        dout_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rx_o,
    output logic        sclk_o,
    output logic        din_o,
    output logic        cs_n_o
);

    localparam int CNT_W = $clog2(HALF_PERIOD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

    typedef struct packed {
        sh_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       bit_idx;
        logic [15:0]      word;
        logic [15:0]      rx;
        logic             sclk;
        logic             din;
        logic             cs_n;
        logic             done;
    } sh_regs_t;

    sh_regs_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        case (q.state)
            SH_IDLE: begin
                if (start_i) begin
                    n.word    = word_i;
                    n.state   = SH_SETUP;
                    n.cnt     = '0;
                    n.cs_n    = 1'b0;
                    n.bit_idx = 4'd15;
                end
            end
            SH_SETUP: begin
                if (q.cnt == CNT_LAST) begin
                    n.state = SH_LOW;
                    n.cnt   = '0;
                    n.sclk  = 1'b0;
                    n.din   = q.word[q.bit_idx];
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            SH_LOW: begin
                if (q.cnt == CNT_LAST) begin
                    n.state = SH_HIGH;
                    n.cnt   = '0;
                    n.sclk  = 1'b1;
                    n.rx    = {q.rx[14:0], dout_i};
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            SH_HIGH: begin
                if (q.cnt == CNT_LAST) begin
                    n.cnt = '0;
                    if (q.bit_idx == 4'd0) begin
                        n.state = SH_GAP;
                        n.cs_n  = 1'b1;
                    end else begin
                        n.bit_idx = q.bit_idx - 1'b1;
                        n.state   = SH_LOW;
                        n.sclk    = 1'b0;
                        n.din     = q.word[n.bit_idx];
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            SH_GAP: begin
                if (q.cnt == CNT_LAST) begin
                    n.state = SH_IDLE;
                    n.cnt   = '0;
                    n.din   = 1'b0;
                    n.done  = 1'b1;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            default: n.state = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= SH_IDLE;
            q.sclk    <= 1'b1;
            q.cs_n    <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy_o = (q.state != SH_IDLE);
    assign done_o = q.done;
    assign rx_o   = q.rx;
    assign sclk_o = q.sclk;
    assign din_o  = q.din;
    assign cs_n_o = q.cs_n;

    // R4: a new word is only requested while the shifter is free
    assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.state == SH_IDLE));

    // R4: the serial clock rests high whenever no DAC is selected
    assert_sclk_rests_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int NUM_DAC    = 4,
    parameter int CH_PER_DAC = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             update_req_i,
    input  logic                             continuous_i,
    input  logic [9:0]                       fix_data_i,
    input  logic                             double_i,
    input  logic                             sh_done_i,
    input  logic [15:0]                      sh_rx_i,
    output logic [$clog2(NUM_DAC*CH_PER_DAC)-1:0] addr_o,
    output logic                             fetch_chan_o,
    output logic                             sh_start_o,
    output logic [15:0]                      sh_word_o,
    output logic [$clog2(NUM_DAC)-1:0]       dac_sel_o,
    output logic                             busy_o,
    output logic [NUM_DAC*CH_PER_DAC-1:0]    set_o,
    output logic [NUM_DAC*CH_PER_DAC-1:0]    dbl_o
);

    localparam int NUM_CH = NUM_DAC * CH_PER_DAC;
    localparam int DAC_W  = $clog2(NUM_DAC);
    localparam int CH_W   = $clog2(CH_PER_DAC);
    localparam int STEP_W = $clog2(CH_PER_DAC + 3);
    localparam logic [STEP_W-1:0] STEP_NOOP  = STEP_W'(CH_PER_DAC);
    localparam logic [STEP_W-1:0] STEP_UPD   = STEP_W'(CH_PER_DAC + 1);
    localparam logic [STEP_W-1:0] STEP_POWER = STEP_W'(CH_PER_DAC + 2);

    typedef struct packed {
        sq_state_e         state;
        logic [DAC_W-1:0]  dac;
        logic [STEP_W-1:0] step;
        logic [15:0]       word;
        logic [15:0]       last_word;
        logic              last_valid;
        logic [CH_W-1:0]   last_ch;
        logic [NUM_CH-1:0] set;
        logic [NUM_CH-1:0] dbl;
        logic              start;
    } sq_regs_t;

    sq_regs_t q, n;

    logic [DAC_W+CH_W-1:0] idx;
    logic [CH_PER_DAC-1:0] grp_mask;
    logic                  in_chan;

    assign idx     = {q.dac, q.step[CH_W-1:0]};
    assign in_chan = (q.step < STEP_NOOP);

    always_comb begin
        n        = q;
        n.start  = 1'b0;
        grp_mask = q.set[q.dac*CH_PER_DAC +: CH_PER_DAC];
        case (q.state)
            SQ_IDLE: begin
                if (update_req_i || continuous_i) begin
                    n.state      = SQ_FETCH;
                    n.dac        = '0;
                    n.step       = '0;
                    n.last_valid = 1'b0;
                end
            end
            SQ_FETCH: begin
                if (in_chan) begin
                    n.dbl[idx] = double_i;
                    if (double_i) begin
                        n.set[idx] = 1'b0;
                        n.step     = q.step + 1'b1;
                    end else begin
                        n.word  = {1'b0, 3'(q.step), fix_data_i, 2'b00};
                        n.state = SQ_SEND;
                    end
                end else begin
                    if (q.step == STEP_NOOP)     n.word = WORD_NOOP;
                    else if (q.step == STEP_UPD) n.word = WORD_UPDATE | 16'(grp_mask);
                    else                         n.word = WORD_POWER | 16'(~grp_mask);
                    n.state = SQ_SEND;
                end
            end
            SQ_SEND: begin
                n.start = 1'b1;
                n.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (sh_done_i) begin
                    if (q.last_valid) n.set[{q.dac, q.last_ch}] = (sh_rx_i == q.last_word);
                    n.last_word  = q.word;
                    n.last_valid = in_chan;
                    n.last_ch    = q.step[CH_W-1:0];
                    n.state      = SQ_FETCH;
                    if (q.step == STEP_POWER) begin
                        n.step       = '0;
                        n.last_valid = 1'b0;
                        if (q.dac == DAC_W'(NUM_DAC - 1)) begin
                            n.dac = '0;
                            if (!continuous_i) n.state = SQ_IDLE;
                        end else begin
                            n.dac = q.dac + 1'b1;
                        end
                    end else begin
                        n.step = q.step + 1'b1;
                    end
                end
            end
            default: n.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SQ_IDLE;
        end else begin
            q <= n;
        end
    end

    assign addr_o       = idx;
    assign fetch_chan_o = (q.state == SQ_FETCH) && in_chan;
    assign sh_start_o   = q.start;
    assign sh_word_o    = q.word;
    assign dac_sel_o    = q.dac;
    assign busy_o       = (q.state != SQ_IDLE);
    assign set_o        = q.set;
    assign dbl_o        = q.dbl;

    // R7: a channel flagged for a double fault is never reported as set
    assert_set_excludes_dbl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o & dbl_o) == '0);

    // R8: a verdict is only taken when the shifter has finished a word
    assert_verdict_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o != $past(set_o) && !$past(fetch_chan_o)) |-> $past(sh_done_i));

endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
    import dac_seq_pkg::*;
#(
    parameter int NUM_DAC     = 4,
    parameter int CH_PER_DAC  = 8,
    parameter int HALF_PERIOD = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          update_req,
    input  logic                          continuous,
    output logic [$clog2(NUM_DAC*CH_PER_DAC)-1:0] mem_addr,
    input  logic [15:0]                   mem_rdata,
    output logic                          mem_we,
    output logic [15:0]                   mem_wdata,
    output logic                          dac_sclk,
    output logic [NUM_DAC-1:0]            dac_cs_n,
    output logic [NUM_DAC-1:0]            dac_din,
    input  logic [NUM_DAC-1:0]            dac_dout,
    output logic                          busy,
    output logic [NUM_DAC*CH_PER_DAC-1:0] set_status,
    output logic [NUM_DAC*CH_PER_DAC-1:0] dbl_err
);

    localparam int DAC_W = $clog2(NUM_DAC);

    logic [15:0]      fixed_word;
    logic             single_err;
    logic             double_err;
    logic             fetch_chan;
    logic             sh_start;
    logic [15:0]      sh_word;
    logic             sh_busy;
    logic             sh_done;
    logic [15:0]      sh_rx;
    logic             sh_sclk;
    logic             sh_din;
    logic             sh_cs_n;
    logic [DAC_W-1:0] dac_sel;

    dac_hamming_dec u_dec (
        .word_i   (mem_rdata),
        .fixed_o  (fixed_word),
        .single_o (single_err),
        .double_o (double_err)
    );

    dac_seq_ctrl #(
        .NUM_DAC    (NUM_DAC),
        .CH_PER_DAC (CH_PER_DAC)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .update_req_i (update_req),
        .continuous_i (continuous),
        .fix_data_i   (fixed_word[9:0]),
        .double_i     (double_err),
        .sh_done_i    (sh_done),
        .sh_rx_i      (sh_rx),
        .addr_o       (mem_addr),
        .fetch_chan_o (fetch_chan),
        .sh_start_o   (sh_start),
        .sh_word_o    (sh_word),
        .dac_sel_o    (dac_sel),
        .busy_o       (busy),
        .set_o        (set_status),
        .dbl_o        (dbl_err)
    );

    dac_word_shifter #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .word_i  (sh_word),
        .dout_i  (dac_dout[dac_sel]),
        .busy_o  (sh_busy),
        .done_o  (sh_done),
        .rx_o    (sh_rx),
        .sclk_o  (sh_sclk),
        .din_o   (sh_din),
        .cs_n_o  (sh_cs_n)
    );

    assign mem_we    = fetch_chan && single_err;
    assign mem_wdata = fixed_word;
    assign dac_sclk  = sh_sclk;

    for (genvar d = 0; d < NUM_DAC; d++) begin : g_lane
        assign dac_cs_n[d] = (dac_sel == DAC_W'(d)) ? sh_cs_n : 1'b1;
        assign dac_din[d]  = (dac_sel == DAC_W'(d)) ? sh_din  : 1'b0;
    end

    // R4: never more than one DAC selected
    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dac_cs_n));

    // R2: an idle block leaves every DAC deselected and the shifter free
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&dac_cs_n && !sh_busy));

    // R6: a write-back repairs exactly one bit of the stored word
    assert_fix_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_wdata ^ mem_rdata) == 1));

endmodule

// File: tb/tb_dac_update_seq.sv
module tb_dac_update_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NDAC = 4;
    localparam int NCH  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        update_req = 1'b0;
    logic        continuous = 1'b0;
    logic [4:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic        dac_sclk;
    logic [3:0]  dac_cs_n;
    logic [3:0]  dac_din;
    logic [3:0]  dac_dout;
    logic        busy;
    logic [31:0] set_status;
    logic [31:0] dbl_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_update_seq dut (
        .clk(clk), .rst_n(rst_n), .update_req(update_req), .continuous(continuous),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_din(dac_din), .dac_dout(dac_dout),
        .busy(busy), .set_status(set_status), .dbl_err(dbl_err)
    );

    // ---------------- memory model ----------------
    logic [15:0] mem [NCH];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // ---------------- DAC models (sampled between edges) ----------------
    logic [15:0] inw  [NDAC];
    logic [15:0] outw [NDAC];
    int          kbit [NDAC];
    logic [15:0] logw [NDAC][16];
    int          sent_cnt [NDAC];
    int          total_words = 0;
    int          fmt_err = 0;
    int          overlap_err = 0;
    logic        corrupt [NCH];
    logic        prev_sclk = 1'b1;
    logic [3:0]  prev_cs = 4'hF;
    logic [3:0]  dout_r;
    assign dac_dout = dout_r;

    initial begin
        for (int d = 0; d < NDAC; d++) begin
            outw[d] = 16'($urandom);
            inw[d] = '0; kbit[d] = 0; sent_cnt[d] = 0;
        end
        dout_r = '0;
    end

    always @(negedge clk) begin
        if ($countones(~dac_cs_n) > 1) overlap_err++;
        for (int d = 0; d < NDAC; d++) begin
            if (!dac_cs_n[d] && prev_sclk && !dac_sclk) dout_r[d] <= outw[d][15 - (kbit[d] % 16)];
            if (!dac_cs_n[d] && !prev_sclk && dac_sclk) begin
                inw[d] = {inw[d][14:0], dac_din[d]};
                kbit[d]++;
            end
            if (!prev_cs[d] && dac_cs_n[d]) begin
                if (kbit[d] != 16) fmt_err++;
                logw[d][sent_cnt[d] % 16] = inw[d];
                sent_cnt[d]++;
                total_words++;
                outw[d] = inw[d];
                if (!inw[d][15] && corrupt[d*8 + int'(inw[d][14:12])]) outw[d] = inw[d] ^ 16'h0001;
                kbit[d] = 0;
            end
        end
        prev_sclk = dac_sclk;
        prev_cs   = dac_cs_n;
    end

    // ---------------- bench reference ----------------
    logic [15:0] clean [NCH];
    int          nerr  [NCH];

    function automatic logic [3:0] ref_pos(input int i);
        case (i)
            0: return 4'd3;  1: return 4'd5;  2: return 4'd6;  3: return 4'd7;
            4: return 4'd9;  5: return 4'd10; 6: return 4'd11; 7: return 4'd12;
            8: return 4'd13; default: return 4'd14;
        endcase
    endfunction

    function automatic logic [15:0] encode(input logic [9:0] d);
        logic [3:0] h = '0;
        for (int i = 0; i < 10; i++) if (d[i]) h = h ^ ref_pos(i);
        return {(^d) ^ (^h), h, 1'b0, d};
    endfunction

    function automatic int usable_bit(input int k);
        return (k < 10) ? k : k + 1;
    endfunction

    function automatic logic exp_set(input int ch);
        return (nerr[ch] != 2) && !corrupt[ch];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0 clean, 1 all single, 2 directed mix, 3 random
    task automatic setup_pass(input int mode);
        for (int ch = 0; ch < NCH; ch++) begin
            logic [15:0] emask;
            int a, b, r;
            clean[ch] = encode(10'($urandom));
            emask = '0;
            corrupt[ch] = 1'b0;
            case (mode)
                0: nerr[ch] = 0;
                1: nerr[ch] = 1;
                2: begin
                    nerr[ch] = (ch / 8 == 1 || ch == 7) ? 2 : 0;
                    corrupt[ch] = (ch / 8 == 2 || ch == 6 || ch == 31);
                end
                default: begin
                    r = int'($urandom % 100);
                    nerr[ch] = (r < 55) ? 0 : (r < 82) ? 1 : 2;
                    corrupt[ch] = (($urandom % 100) < 15);
                end
            endcase
            if (nerr[ch] >= 1) begin
                a = (mode == 1) ? (ch % 15) : int'($urandom % 15);
                emask[usable_bit(a)] = 1'b1;
            end
            if (nerr[ch] == 2) begin
                b = (a + 1 + int'($urandom % 14)) % 15;
                emask[usable_bit(b)] = 1'b1;
            end
            mem[ch] <= clean[ch] ^ emask;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 40000) begin @(negedge clk); n++; end
        check(!busy, "R3 pass end", 32'(busy), 32'd0);
    endtask

    task automatic check_pass(input string tag, input int base [NDAC]);
        for (int d = 0; d < NDAC; d++) begin
            logic [15:0] expw [16];
            logic [7:0]  mask = '0;
            int ne = 0;
            int got;
            bit ok = 1;
            int bad = 0;
            for (int c = 0; c < 8; c++) begin
                int ch = d*8 + c;
                if (nerr[ch] != 2) begin
                    expw[ne] = {1'b0, 3'(c), clean[ch][9:0], 2'b00};
                    ne++;
                end
                mask[c] = exp_set(ch);
            end
            expw[ne] = 16'h8000; expw[ne+1] = 16'hA000 | 16'(mask); expw[ne+2] = 16'hC000 | 16'(~mask);
            got = sent_cnt[d] - base[d];
            check(got == ne + 3, "R7 words sent per DAC", 32'(got), 32'(ne + 3));
            for (int j = 0; j < ne && j < got; j++)
                if (logw[d][(base[d] + j) % 16] !== expw[j]) begin ok = 0; bad = j; end
            check(ok, "R5/R6 channel words and order", 32'(logw[d][(base[d]+bad)%16]), 32'(expw[bad]));
            check(logw[d][(base[d]+ne)%16] === 16'h8000, "R5 NOOP word", 32'(logw[d][(base[d]+ne)%16]), 32'h8000);
            check(logw[d][(base[d]+ne+1)%16] === expw[ne+1], "R9 update word",
                  32'(logw[d][(base[d]+ne+1)%16]), 32'(expw[ne+1]));
            check(logw[d][(base[d]+ne+2)%16] === expw[ne+2], "R9 power word",
                  32'(logw[d][(base[d]+ne+2)%16]), 32'(expw[ne+2]));
        end
        for (int ch = 0; ch < NCH; ch++) begin
            check(set_status[ch] === exp_set(ch), {tag, " R8/R10 set status"}, 32'(ch), 32'(exp_set(ch)));
            check(dbl_err[ch] === (nerr[ch] == 2), "R7 double flag", 32'(dbl_err[ch]), 32'(nerr[ch] == 2));
            if (nerr[ch] == 1) begin
                check(mem[ch] === clean[ch], "R6 write-back", 32'(mem[ch]), 32'(clean[ch]));
                nerr[ch] = 0;
            end
        end
        check(fmt_err == 0 && overlap_err == 0, "R4 framing", 32'(fmt_err + overlap_err), 32'd0);
    endtask

    task automatic run_pass(input int mode, input string tag);
        int base [NDAC];
        setup_pass(mode);
        @(negedge clk);
        for (int d = 0; d < NDAC; d++) base[d] = sent_cnt[d];
        update_req = 1'b1;
        @(negedge clk);
        update_req = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R2 start on request", 32'(busy), 32'd1);
        wait_idle();
        check_pass(tag, base);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 180000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int dummy;
        int base_w;
        int exp_words;
        bit stayed;
        dummy = int'($urandom(32'd1234));
        for (int ch = 0; ch < NCH; ch++) begin corrupt[ch] = 1'b0; nerr[ch] = 0; mem[ch] <= '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
        check(dac_cs_n === 4'hF, "R1 selects after reset", 32'(dac_cs_n), 32'hF);
        check(dac_sclk === 1'b1, "R1 sclk after reset", 32'(dac_sclk), 32'd1);
        check(set_status === '0 && dbl_err === '0, "R1 status after reset", set_status | dbl_err, 32'd0);

        repeat (40) @(negedge clk);
        check(busy === 1'b0 && total_words == 0, "R2 no start without request", 32'(total_words), 32'd0);

        run_pass(0, "clean R10");
        run_pass(1, "single");
        run_pass(2, "mixed");
        for (int p = 0; p < 4; p++) run_pass(3, "random");

        // continuous mode
        setup_pass(3);
        @(negedge clk);
        exp_words = 0;
        for (int ch = 0; ch < NCH; ch++) if (nerr[ch] != 2) exp_words++;
        exp_words += 3 * NDAC;
        base_w = total_words;
        continuous = 1'b1;
        @(negedge clk);
        @(negedge clk);
        stayed = 1;
        while (total_words - base_w < 2 * exp_words + 2) begin
            @(negedge clk);
            if (!busy) stayed = 0;
        end
        check(stayed && busy, "R3 continuous cycling", 32'(busy), 32'd1);
        continuous = 1'b0;
        wait_idle();
        for (int ch = 0; ch < NCH; ch++) begin
            check(set_status[ch] === exp_set(ch), "R3 R8 status after continuous", 32'(ch), 32'(exp_set(ch)));
            if (nerr[ch] == 1) check(mem[ch] === clean[ch], "R6 write-back continuous", 32'(mem[ch]), 32'(clean[ch]));
        end
        check((total_words - base_w) % exp_words == 0, "R3 whole passes only",
              32'(total_words - base_w), 32'(exp_words));

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule